// File: doc/BRIEF.md
# HDB3 Line Encoder with Dual Return-to-Zero Rails

This block turns a serial NRZ bit stream, one bit per clock, into HDB3 pseudo-ternary line code. A mark is sent as a pulse on one of two rail outputs: rail A carries positive marks and rail B carries negative marks. Ordinary ones alternate between the rails. Any run of four zeros is rewritten as either `000V` or `B00V`, and the choice keeps successive violations opposite in polarity, so the line has no DC component and enough transitions for clock recovery.

Each rail is a return-to-zero pulse. A rail is forced low while the clock is high and may go high only in the low half of the clock. A four-slot lookahead pipeline holds every bit until the encoder knows whether that bit begins a zero run. Because of this, a balancing pulse can be placed on the first zero of a run before that zero leaves the pipeline. A separate output gives the raw input delayed by one clock period, for local loopback or monitoring.

Top module: `hdb3_rail_encoder`

## Requirements
- R1: Both rail outputs are low whenever `clk_i` is high.
- R2: The two rails are never high at the same time. Each bit slot carries at most one pulse.
- R3: `data_dly_o` equals the value of `data_i` sampled at the previous rising edge of `clk_i`.
- R4: The bit sampled at rising edge n is sent in the clock-low half that follows rising edge n+4. The rails stay silent in the first four low halves after reset is released.
- R5: Ordinary ones alternate between the rails. The first mark after reset goes on rail A (`rail_a_o`).
- R6: No four consecutive bit slots on the line are empty. Every run of four input zeros carries a violation pulse in its fourth slot.
- R7: A zero run becomes `000V` when an odd number of pulses has been sent since the last violation, and `B00V` when that number is even. A balancing pulse `B` counts as a pulse. After reset the count is even.
- R8: A violation pulse takes the polarity of the pulse sent just before it. A balancing pulse takes the polarity opposite to the pulse sent just before it.
- R9: While `rst_ni` is low, all outputs are low, whatever `data_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; its low half gates the rail pulses |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | NRZ input bit, sampled on the rising edge |
| rail_a_o | output | 1 | Positive-polarity mark, return-to-zero |
| rail_b_o | output | 1 | Negative-polarity mark, return-to-zero |
| data_dly_o | output | 1 | Input data delayed by one clock period |

## Verification
The assertions assume that reset is applied before the first data bit, so that the pipeline slots start out marked as empty and the polarity state starts at its defined values. They also assume that `data_i` is stable across the rising edge, which lets the lookahead property tie a stored violation back to the zero that was sampled at that edge. The stimulus changes `data_i` only at falling edges, and it releases reset at a falling edge before each pattern. It observes the rails in the low half of the clock, and also just after the rising edge to confirm that both rails are low.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  localparam int HDB3_RUN = 4;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_BAL  = 2'd2,
    SYM_VIOL = 2'd3
  } sym_e;

  typedef struct packed {
    logic vld;
    sym_e sym;
  } slot_t;
endpackage

// File: rtl/hdb3_lookahead.sv
module hdb3_lookahead
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = HDB3_RUN
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  data_i,
  input  logic  even_i,
  output slot_t head_o
);
  localparam int LAST = RUN_LEN - 1;

  slot_t st_q [RUN_LEN];
  slot_t nxt  [RUN_LEN];
  logic  run_in;

  always_comb begin
    nxt[0].vld = 1'b1;
    nxt[0].sym = data_i ? SYM_MARK : SYM_ZERO;
    for (int k = 1; k < RUN_LEN; k++) nxt[k] = st_q[k-1];
    run_in = 1'b1;
    for (int k = 0; k < RUN_LEN; k++)
      run_in = run_in & nxt[k].vld & (nxt[k].sym == SYM_ZERO);
    // even_i reflects the slot leaving this edge, so the decision sees every emitted pulse
    if (run_in) begin
      nxt[LAST].sym = even_i ? SYM_BAL : SYM_ZERO;
      nxt[0].sym    = SYM_VIOL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < RUN_LEN; k++) st_q[k] <= '0;
    end else begin
      for (int k = 0; k < RUN_LEN; k++) st_q[k] <= nxt[k];
    end
  end

  assign head_o = st_q[LAST];

  logic run_held, lead_zero;
  always_comb begin
    run_held  = 1'b1;
    lead_zero = 1'b1;
    for (int k = 0; k < RUN_LEN; k++)
      run_held = run_held & st_q[k].vld & (st_q[k].sym == SYM_ZERO);
    for (int k = 0; k < LAST; k++)
      lead_zero = lead_zero & st_q[k].vld & (st_q[k].sym == SYM_ZERO);
  end

  a_r6_no_zero_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_held);

  a_r6_viol_after_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[0].vld && st_q[0].sym == SYM_VIOL) |-> $past(lead_zero && !data_i));
endmodule

// File: rtl/hdb3_polarity.sv
module hdb3_polarity
  import hdb3_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_t head_i,
  output logic  even_o,
  output logic  pos_o,
  output logic  neg_o
);
  logic last_pos_q, odd_q, pos_q, neg_q;
  logic is_pulse, is_viol, is_flip, pulse_pos;

  assign is_pulse  = head_i.vld && (head_i.sym != SYM_ZERO);
  assign is_viol   = head_i.vld && (head_i.sym == SYM_VIOL);
  assign is_flip   = head_i.vld && (head_i.sym == SYM_MARK || head_i.sym == SYM_BAL);
  assign pulse_pos = is_viol ? last_pos_q : !last_pos_q;

  // parity as it stands once the head slot has left
  always_comb begin
    if (is_viol)      even_o = 1'b1;
    else if (is_flip) even_o = odd_q;
    else              even_o = !odd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pos_q <= 1'b0;
      odd_q      <= 1'b0;
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
    end else begin
      pos_q <= is_pulse && pulse_pos;
      neg_q <= is_pulse && !pulse_pos;
      if (is_pulse) last_pos_q <= pulse_pos;
      if (is_viol)      odd_q <= 1'b0;
      else if (is_flip) odd_q <= !odd_q;
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;

  a_r2_rails_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pos_q, neg_q}));

  a_r8_viol_same_pol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_viol |=> (pos_q == $past(last_pos_q)) && (pos_q != neg_q));

  a_r5_mark_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_flip |=> (pos_q != $past(last_pos_q)) && (pos_q != neg_q));

  a_r7_even_after_viol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_viol |=> !odd_q);
endmodule

// File: rtl/hdb3_rail_encoder.sv
module hdb3_rail_encoder
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = HDB3_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic rail_a_o,
  output logic rail_b_o,
  output logic data_dly_o
);
  slot_t head;
  logic  even, pos, neg, dly_q;

  hdb3_lookahead #(.RUN_LEN(RUN_LEN)) u_look (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .even_i (even),
    .head_o (head)
  );

  hdb3_polarity u_pol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .head_i (head),
    .even_o (even),
    .pos_o  (pos),
    .neg_o  (neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= data_i;
  end

  // pulse registers change on the rising edge, while the gate is closed
  assign rail_a_o   = pos & ~clk_i;
  assign rail_b_o   = neg & ~clk_i;
  assign data_dly_o = dly_q;

  a_r9_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !pos && !neg && !data_dly_o);
endmodule

// File: tb/hdb3_rail_encoder_tb_top.sv
module hdb3_rail_encoder_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic rail_a_o, rail_b_o, data_dly_o;

  always #4 clk = ~clk;

  hdb3_rail_encoder dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .rail_a_o   (rail_a_o),
    .rail_b_o   (rail_b_o),
    .data_dly_o (data_dly_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  localparam int NVEC = 8;
  localparam logic [63:0] VEC_PAT [NVEC] = '{
    64'h0000_0000_0000_FFFF,
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0001,
    64'h0000_0000_0000_0003,
    64'h0000_0000_0000_5555,
    64'h0000_0000_F0F0_0F0F,
    64'h8000_0421_0090_0103,
    64'h0000_0000_0001_0801
  };
  localparam int VEC_LEN [NVEC] = '{16, 20, 12, 12, 16, 32, 64, 48};

  bit bits_a [80];
  int exp_a  [80];

  // reference: 0 empty, 1 rail A, 2 rail B
  task automatic build_expect(input int n);
    int i = 0;
    bit odd = 1'b0;
    bit last_a = 1'b0;
    for (int k = 0; k < 80; k++) exp_a[k] = 0;
    while (i < n) begin
      if (i + 3 < n && !bits_a[i] && !bits_a[i+1] && !bits_a[i+2] && !bits_a[i+3]) begin
        if (!odd) begin
          last_a = !last_a;
          exp_a[i] = last_a ? 1 : 2;
        end
        exp_a[i+3] = last_a ? 1 : 2;
        odd = 1'b0;
        i += 4;
      end else begin
        if (bits_a[i]) begin
          last_a = !last_a;
          exp_a[i] = last_a ? 1 : 2;
          odd = !odd;
        end
        i++;
      end
    end
  endtask

  function automatic int rail_code();
    return {30'd0, rail_b_o, rail_a_o} == 1 ? 1 :
           {30'd0, rail_b_o, rail_a_o} == 2 ? 2 :
           {30'd0, rail_b_o, rail_a_o} == 3 ? 3 : 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    data_i = 1'b1;
    rst_ni = 1'b0;
    #1;
    chk(!rail_a_o && !rail_b_o && !data_dly_o, "R9 outputs low on reset entry",
        {rail_a_o, rail_b_o, data_dly_o}, 0);
    repeat (2) @(negedge clk);
    #1;
    chk(!rail_a_o && !rail_b_o && !data_dly_o, "R9 outputs low while held in reset",
        {rail_a_o, rail_b_o, data_dly_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    data_i = 1'b0;
  endtask

  task automatic stream(input int n, input int vec);
    for (int c = 0; c < n; c++) begin
      data_i = bits_a[c];
      #2;
      chk(data_dly_o == (c > 0 ? bits_a[c-1] : 1'b0), "R3 delayed data",
          data_dly_o, c > 0 ? bits_a[c-1] : 0);
      chk(!(rail_a_o && rail_b_o), "R2 rails exclusive", rail_code(), 0);
      if (c < 5)
        chk(rail_code() == 0, "R4 silent while pipeline fills", rail_code(), 0);
      else
        chk(rail_code() == exp_a[c-5], $sformatf("R4 R5 R7 R8 vec %0d bit %0d", vec, c-5),
            rail_code(), exp_a[c-5]);
      @(posedge clk);
      #1;
      chk(!rail_a_o && !rail_b_o, "R1 rails low in clock-high half", rail_code(), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      for (int k = 0; k < 80; k++)
        bits_a[k] = (k < VEC_LEN[v]) ? VEC_PAT[v][k] : 1'b0;
      build_expect(VEC_LEN[v] + 5);
      stream(VEC_LEN[v] + 5, v);
    end

    // R5: the first mark after reset lands on rail A
    do_reset();
    for (int k = 0; k < 80; k++) bits_a[k] = (k == 0);
    build_expect(6);
    stream(6, 100);
    chk(exp_a[0] == 1, "R5 reference first mark on rail A", exp_a[0], 1);

    // R6: long zero stream never leaves four empty slots
    do_reset();
    begin
      int run = 0;
      int worst = 0;
      int pulses = 0;
      for (int c = 0; c < 45; c++) begin
        data_i = 1'b0;
        #2;
        if (c >= 5) begin
          if (rail_a_o || rail_b_o) begin
            run = 0;
            pulses++;
          end else begin
            run++;
            if (run > worst) worst = run;
          end
        end
        @(negedge clk);
      end
      chk(worst <= 3, "R6 longest empty run on zeros", worst, 3);
      chk(pulses >= 10, "R6 violations present on zeros", pulses, 10);
    end

    // R9: reset mid-stream silences everything at once
    data_i = 1'b1;
    repeat (8) @(negedge clk);
    do_reset();
    #2;
    chk(rail_code() == 0 && !data_dly_o, "R9 quiet right after release", rail_code(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule